// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside an embedded flash array and watches the word-wide write bus into the flash region. It recognises the multi-write unlock sequences that software uses to request flash operations. When a complete sequence is seen, it raises exactly one single-cycle command pulse for an external program/erase engine. The commands are reset-to-read, word program, chip erase, sector erase, erase suspend and erase resume. With the program pulse it presents the captured program address and data word. With the sector erase pulse it presents the captured sector address. While a sector erase is parked, it holds a suspended flag.

Every valid unlock sequence begins with two key writes: low byte AA to low address AAAA, then low byte 55 to low address 5554. The third write, to AAAA, carries the command byte. A0 arms a program, so the fourth write becomes the program write. 80 arms erase, which needs the two key writes again and then a sixth write. That sixth write is 10 at AAAA for chip erase, or 30 at the target sector for sector erase. A lone F0 acts as a reset at any point. Any write that breaks a sequence drops it quietly. Only addresses whose top six bits are all ones (banks FC to FF) belong to the region.

State names and transitions: READ (idle) goes to KEY1 on AA@AAAA. KEY1 goes to KEY2 on 55@5554. KEY2 goes to PROG on A0@AAAA, or to ESETUP on 80@AAAA. PROG always returns to READ, issuing a program pulse for an even address or an error pulse for an odd one. ESETUP goes to EKEY1 on AA@AAAA. EKEY1 goes to EKEY2 on 55@5554. EKEY2 returns to READ, issuing chip erase for 10@AAAA or sector erase for 30@any address. From any state, F0 issues a reset and returns to READ, except in PROG, where F0 is program data. Any other write in a sequence state returns to READ silently. SUSP is entered from any state on B0 while a sector erase runs. SUSP returns to READ on 30.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write whose address bits [23:18] are not all ones changes nothing: no pulse is issued and a sequence in progress continues as if the write never happened.
- R2: A write with low data byte F0 issues cmd_reset for one cycle and returns to READ. This applies from READ or any sequence state except PROG. The same holds for the four-write form AA@AAAA, 55@5554, F0@AAAA.
- R3: The sequence AA@AAAA, 55@5554, A0@AAAA, then a write to an even address issues cmd_program. prog_addr and prog_data hold that fourth write's full address and full 16-bit data from the pulse cycle onward.
- R4: If the fourth write of a program sequence has address bit 0 set, prog_error pulses for one cycle and cmd_program stays low.
- R5: The sequence AA@AAAA, 55@5554, 80@AAAA, AA@AAAA, 55@5554, 10@AAAA issues cmd_chip_erase.
- R6: The same five erase-setup writes followed by 30 at any address issue cmd_sector_erase. sector_addr holds that sixth write's address.
- R7: Only bits [7:0] of the write data are compared with command codes; bits [15:8] are ignored.
- R8: A write that does not match the next expected address/data pair returns the decoder to READ without any pulse, so a later lone write cannot complete the broken sequence.
- R9: While eng_busy is high and eng_sector is low, every write is discarded. No pulse is issued, not even a reset.
- R10: While eng_busy and eng_sector are both high, a B0 write issues cmd_suspend and raises suspended. All other writes issue nothing.
- R11: While suspended is high, a write of 30 to any address issues cmd_resume and clears suspended. All other writes issue nothing and leave suspended set.
- R12: Every command pulse lasts one cycle. At most one of the seven pulse outputs is high in any cycle. Each pulse appears in the cycle after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 24 | Write byte address |
| wr_data | input | 16 | Write data word |
| eng_busy | input | 1 | Engine is running a program or erase |
| eng_sector | input | 1 | Running operation is a sector erase |
| cmd_reset | output | 1 | Reset-to-read pulse |
| cmd_program | output | 1 | Word program pulse |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_sector_erase | output | 1 | Sector erase pulse |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| prog_error | output | 1 | Odd program address pulse |
| prog_addr | output | 24 | Captured program address |
| prog_data | output | 16 | Captured program data |
| sector_addr | output | 24 | Captured sector address |
| suspended | output | 1 | Sector erase is suspended |

## Verification
On every cycle, the assertions check the following:
- the pulse outputs are mutually exclusive;
- an out-of-region write leaves the state untouched;
- a busy engine suppresses every pulse except suspend;
- the suspended flag rises only with a suspend pulse and falls only with a resume pulse;
- a program pulse never carries an odd address.

Only the bench's scenarios can show that whole sequences complete, and that broken or high-byte-garbled ones behave as required. They also show that captured addresses and data are correct, and that a lone reset or resume works from each situation.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int LOW_W = 16;
    localparam logic [LOW_W-1:0] KEY_ADDR_A = 16'hAAAA;
    localparam logic [LOW_W-1:0] KEY_ADDR_B = 16'h5554;
    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_RESET   = 8'hF0;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_ESETUP  = 8'h80;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;
    localparam logic [7:0] CODE_SUSPEND = 8'hB0;
    localparam logic [7:0] CODE_RESUME  = 8'h30;

    typedef enum logic [2:0] {
        ST_READ, ST_KEY1, ST_KEY2, ST_PROG,
        ST_ESETUP, ST_EKEY1, ST_EKEY2, ST_SUSP
    } fcd_state_e;

    typedef enum logic [2:0] {
        EV_NONE, EV_RESET, EV_PROG, EV_CHIP,
        EV_SECTOR, EV_SUSPEND, EV_RESUME, EV_PERR
    } fcd_event_e;

    typedef struct packed {
        logic       hit;
        logic       key_a;
        logic       key_b;
        logic       even;
        logic [7:0] code;
    } fcd_decode_t;
endpackage

// File: rtl/fcd_match.sv
module fcd_match
    import fcd_pkg::*;
#(
    parameter int BANK_W = 6,
    parameter logic [BANK_W-1:0] BANK_VAL = '1
) (
    input  logic              wr_en,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [LOW_W-1:0]  low_i,
    input  logic [7:0]        code_i,
    output fcd_decode_t       dec,
    output logic              bank_miss
);
    logic in_region;

    always_comb begin
        in_region = (bank_i == BANK_VAL);
        dec.hit   = wr_en && in_region;
        dec.key_a = (low_i == KEY_ADDR_A);
        dec.key_b = (low_i == KEY_ADDR_B);
        dec.even  = ~low_i[0];
        dec.code  = code_i;
        bank_miss = wr_en && !in_region;
    end
endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fcd_decode_t       dec,
    input  logic              bank_miss,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_sector,
    output logic              cmd_reset,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              prog_error,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic [ADDR_W-1:0] sector_addr,
    output logic              suspended
);
    fcd_state_e st, st_n;
    fcd_event_e ev_n;
    logic       is_reset;

    // next state and event
    always_comb begin
        st_n     = st;
        ev_n     = EV_NONE;
        is_reset = (dec.code == CODE_RESET);
        if (dec.hit) begin
            if (st == ST_SUSP) begin
                if (dec.code == CODE_RESUME) begin
                    ev_n = EV_RESUME;
                    st_n = ST_READ;
                end
            end else if (eng_busy && eng_sector) begin
                if (dec.code == CODE_SUSPEND) begin
                    ev_n = EV_SUSPEND;
                    st_n = ST_SUSP;
                end else begin
                    st_n = ST_READ;
                end
            end else if (eng_busy) begin
                st_n = ST_READ;
            end else begin
                st_n = ST_READ;
                unique case (st)
                    ST_READ: begin
                        if (dec.key_a && dec.code == CODE_KEY_A) st_n = ST_KEY1;
                        else if (is_reset)                       ev_n = EV_RESET;
                    end
                    ST_KEY1: begin
                        if (dec.key_b && dec.code == CODE_KEY_B) st_n = ST_KEY2;
                        else if (is_reset)                       ev_n = EV_RESET;
                    end
                    ST_KEY2: begin
                        if (dec.key_a && dec.code == CODE_PROG)        st_n = ST_PROG;
                        else if (dec.key_a && dec.code == CODE_ESETUP) st_n = ST_ESETUP;
                        else if (is_reset)                             ev_n = EV_RESET;
                    end
                    ST_PROG: begin
                        ev_n = dec.even ? EV_PROG : EV_PERR;
                    end
                    ST_ESETUP: begin
                        if (dec.key_a && dec.code == CODE_KEY_A) st_n = ST_EKEY1;
                        else if (is_reset)                       ev_n = EV_RESET;
                    end
                    ST_EKEY1: begin
                        if (dec.key_b && dec.code == CODE_KEY_B) st_n = ST_EKEY2;
                        else if (is_reset)                       ev_n = EV_RESET;
                    end
                    ST_EKEY2: begin
                        if (dec.key_a && dec.code == CODE_CHIP) ev_n = EV_CHIP;
                        else if (dec.code == CODE_SECTOR)       ev_n = EV_SECTOR;
                        else if (is_reset)                      ev_n = EV_RESET;
                    end
                    ST_SUSP: st_n = ST_SUSP;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READ;
        else        st <= st_n;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_reset        <= 1'b0;
            cmd_program      <= 1'b0;
            cmd_chip_erase   <= 1'b0;
            cmd_sector_erase <= 1'b0;
            cmd_suspend      <= 1'b0;
            cmd_resume       <= 1'b0;
            prog_error       <= 1'b0;
            prog_addr        <= '0;
            prog_data        <= '0;
            sector_addr      <= '0;
        end else begin
            cmd_reset        <= (ev_n == EV_RESET);
            cmd_program      <= (ev_n == EV_PROG);
            cmd_chip_erase   <= (ev_n == EV_CHIP);
            cmd_sector_erase <= (ev_n == EV_SECTOR);
            cmd_suspend      <= (ev_n == EV_SUSPEND);
            cmd_resume       <= (ev_n == EV_RESUME);
            prog_error       <= (ev_n == EV_PERR);
            if (ev_n == EV_PROG) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (ev_n == EV_SECTOR) sector_addr <= wr_addr;
        end
    end

    assign suspended = (st == ST_SUSP);

    logic [6:0] pulses;
    assign pulses = {cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase,
                     cmd_suspend, cmd_resume, prog_error};

    // R12: pulse outputs are mutually exclusive
    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    // R1: an out-of-region write leaves state alone and issues nothing
    a_r1_bank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bank_miss |=> ($stable(st) && pulses == 7'd0));

    // R9: busy with program or chip erase suppresses every pulse
    a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_sector && st != ST_SUSP) |=> (pulses == 7'd0));

    // R10: during sector erase only a suspend pulse may appear
    a_r10_sector_only_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && eng_sector && st != ST_SUSP) |=> (pulses == 7'd0 || cmd_suspend));

    // R10: suspended rises only with a suspend pulse
    a_r10_rise_with_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> cmd_suspend);

    // R11: suspended falls only with a resume pulse
    a_r11_fall_with_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(suspended) |-> cmd_resume);

    // R4: a program pulse never carries an odd address
    a_r4_even_program: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_program |-> !prog_addr[0]);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_busy,
    input  logic              eng_sector,
    output logic              cmd_reset,
    output logic              cmd_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              prog_error,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic [ADDR_W-1:0] sector_addr,
    output logic              suspended
);
    localparam logic [BANK_W-1:0] BANK_VAL = '1;

    fcd_decode_t dec;
    logic        bank_miss;

    fcd_match #(.BANK_W(BANK_W), .BANK_VAL(BANK_VAL)) u_match (
        .wr_en     (wr_en),
        .bank_i    (wr_addr[ADDR_W-1 -: BANK_W]),
        .low_i     (wr_addr[LOW_W-1:0]),
        .code_i    (wr_data[7:0]),
        .dec       (dec),
        .bank_miss (bank_miss)
    );

    fcd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .dec              (dec),
        .bank_miss        (bank_miss),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .eng_busy         (eng_busy),
        .eng_sector       (eng_sector),
        .cmd_reset        (cmd_reset),
        .cmd_program      (cmd_program),
        .cmd_chip_erase   (cmd_chip_erase),
        .cmd_sector_erase (cmd_sector_erase),
        .cmd_suspend      (cmd_suspend),
        .cmd_resume       (cmd_resume),
        .prog_error       (prog_error),
        .prog_addr        (prog_addr),
        .prog_data        (prog_data),
        .sector_addr      (sector_addr),
        .suspended        (suspended)
    );
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    // 50 MHz clock: 20 time units per period
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        eng_busy = 1'b0;
    logic        eng_sector = 1'b0;
    logic        cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase;
    logic        cmd_suspend, cmd_resume, prog_error, suspended;
    logic [23:0] prog_addr, sector_addr;
    logic [15:0] prog_data;

    int errors = 0;
    int checks = 0;

    localparam logic [6:0] P_NONE = 7'b0000000;
    localparam logic [6:0] P_RST  = 7'b1000000;
    localparam logic [6:0] P_PROG = 7'b0100000;
    localparam logic [6:0] P_CHIP = 7'b0010000;
    localparam logic [6:0] P_SECT = 7'b0001000;
    localparam logic [6:0] P_SUSP = 7'b0000100;
    localparam logic [6:0] P_RES  = 7'b0000010;
    localparam logic [6:0] P_PERR = 7'b0000001;

    always #10 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_busy(eng_busy), .eng_sector(eng_sector),
        .cmd_reset(cmd_reset), .cmd_program(cmd_program),
        .cmd_chip_erase(cmd_chip_erase), .cmd_sector_erase(cmd_sector_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .prog_error(prog_error), .prog_addr(prog_addr), .prog_data(prog_data),
        .sector_addr(sector_addr), .suspended(suspended)
    );

    function automatic logic [6:0] pulses();
        return {cmd_reset, cmd_program, cmd_chip_erase, cmd_sector_erase,
                cmd_suspend, cmd_resume, prog_error};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one bus write; the pulse vector is checked one cycle later (R12)
    task automatic wr(input logic [23:0] a, input logic [15:0] d,
                      input logic [6:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(pulses() == exp, req, "pulse", {25'd0, pulses()}, {25'd0, exp});
    endtask

    task automatic unlock(input logic [7:0] bank, input logic [7:0] cmd, input string req);
        wr({bank, 16'hAAAA}, 16'h00AA, P_NONE, req);
        wr({bank, 16'h5554}, 16'h0055, P_NONE, req);
        wr({bank, 16'hAAAA}, {8'h00, cmd}, P_NONE, req);
    endtask

    task automatic t_reset_state();
        check(pulses() == P_NONE && !suspended, "R12", "reset pulses", {25'd0, pulses()}, 0);
        check(prog_addr == 0 && sector_addr == 0 && prog_data == 0, "R3",
              "reset captures", prog_addr, 0);
    endtask

    task automatic t_reset_cmds();
        wr(24'hFC1234, 16'h00F0, P_RST, "R2");        // lone reset
        wr(24'hFFAAAA, 16'h00AA, P_NONE, "R2");
        wr(24'hFF5554, 16'h0055, P_NONE, "R2");
        wr(24'hFFAAAA, 16'h00F0, P_RST, "R2");        // four-write reset form
        wr(24'hFEAAAA, 16'h00AA, P_NONE, "R2");
        wr(24'hFE0000, 16'h77F0, P_RST, "R2");        // reset mid-sequence, high byte ignored (R7)
    endtask

    task automatic t_program();
        wr(24'hFEAAAA, 16'h12AA, P_NONE, "R7");
        wr(24'hFE5554, 16'h3455, P_NONE, "R7");
        wr(24'hFEAAAA, 16'h56A0, P_NONE, "R7");
        wr(24'hFE0100, 16'hBEEF, P_PROG, "R3");
        check(prog_addr == 24'hFE0100, "R3", "prog_addr", prog_addr, 24'hFE0100);
        check(prog_data == 16'hBEEF, "R3", "prog_data", prog_data, 16'hBEEF);
        @(negedge clk);
        check(!cmd_program, "R12", "pulse width", cmd_program, 0);
        // F0 as program data is data, not reset
        unlock(8'hFD, 8'hA0, "R3");
        wr(24'hFD0002, 16'h00F0, P_PROG, "R3");
        check(prog_data == 16'h00F0, "R3", "prog_data F0", prog_data, 16'h00F0);
    endtask

    task automatic t_odd();
        unlock(8'hFF, 8'hA0, "R4");
        wr(24'hFF0101, 16'h1111, P_PERR, "R4");
        check(prog_addr == 24'hFD0002, "R4", "prog_addr kept", prog_addr, 24'hFD0002);
    endtask

    task automatic t_erase();
        unlock(8'hFC, 8'h80, "R5");
        wr(24'hFCAAAA, 16'h00AA, P_NONE, "R5");
        wr(24'hFC5554, 16'h0055, P_NONE, "R5");
        wr(24'hFCAAAA, 16'h0010, P_CHIP, "R5");
        unlock(8'hFD, 8'h80, "R6");
        wr(24'hFDAAAA, 16'h00AA, P_NONE, "R6");
        wr(24'hFD5554, 16'h0055, P_NONE, "R6");
        wr(24'hFD4000, 16'h9930, P_SECT, "R6");
        check(sector_addr == 24'hFD4000, "R6", "sector_addr", sector_addr, 24'hFD4000);
    endtask

    task automatic t_abort();
        wr(24'hFFAAAA, 16'h00AA, P_NONE, "R8");
        wr(24'hFF5554, 16'h0055, P_NONE, "R8");
        wr(24'hFFAAAA, 16'h0077, P_NONE, "R8");      // bad command byte
        wr(24'hFF0200, 16'h1234, P_NONE, "R8");      // would be program data
        wr(24'hFFAAAA, 16'h00AA, P_NONE, "R8");
        wr(24'hFF1234, 16'h0055, P_NONE, "R8");      // wrong address
        wr(24'hFFAAAA, 16'h00A0, P_NONE, "R8");
        wr(24'hFF0300, 16'h4321, P_NONE, "R8");
    endtask

    task automatic t_bank();
        wr(24'hFFAAAA, 16'h00AA, P_NONE, "R1");
        wr(24'h7F5554, 16'h00F0, P_NONE, "R1");      // outside region: no reset, no abort
        wr(24'hFF5554, 16'h0055, P_NONE, "R1");
        wr(24'hFFAAAA, 16'h00A0, P_NONE, "R1");
        wr(24'hFF0400, 16'hCAFE, P_PROG, "R1");
        check(prog_addr == 24'hFF0400, "R1", "prog_addr", prog_addr, 24'hFF0400);
    endtask

    task automatic t_busy();
        eng_busy = 1'b1; eng_sector = 1'b0;
        unlock(8'hFE, 8'hA0, "R9");
        wr(24'hFE0500, 16'h5555, P_NONE, "R9");
        wr(24'hFE0000, 16'h00F0, P_NONE, "R9");
        wr(24'hFE0000, 16'h00B0, P_NONE, "R9");
        eng_busy = 1'b0;
        check(prog_addr == 24'hFF0400, "R9", "prog_addr kept", prog_addr, 24'hFF0400);
    endtask

    task automatic t_suspend();
        eng_busy = 1'b1; eng_sector = 1'b1;
        wr(24'hFC0000, 16'h00F0, P_NONE, "R10");
        wr(24'hFC0000, 16'h0030, P_NONE, "R10");
        check(!suspended, "R10", "not yet suspended", suspended, 0);
        wr(24'hFC0010, 16'hEEB0, P_SUSP, "R10");
        check(suspended, "R10", "suspended", suspended, 1);
        eng_busy = 1'b0; eng_sector = 1'b0;
        wr(24'hFC0000, 16'h00F0, P_NONE, "R11");
        wr(24'hFCAAAA, 16'h00AA, P_NONE, "R11");
        check(suspended, "R11", "still suspended", suspended, 1);
        wr(24'hFE8888, 16'h1230, P_RES, "R11");
        check(!suspended, "R11", "resumed", suspended, 0);
        wr(24'hFC0000, 16'h00F0, P_RST, "R11");      // back in read mode
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reset_cmds();
        t_program();
        t_odd();
        t_erase();
        t_abort();
        t_bank();
        t_busy();
        t_suspend();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule